// File: doc/BRIEF.md
# Per-pin pad ownership and input-change controller

This block sits between a group of pads and the internal peripherals that want to use them. For every pin, a software-written ownership bit picks the pad's driver. When the bit is 1, software output data and a software output enable drive the pad. When it is 0, the peripheral's own output and enable drive it. Out of reset every pin belongs to software with its output disabled, so all pads start as inputs. A peripheral signal reaches its pad only after software hands that pin over.

On the input side, each pad passes through a two-flop synchronizer. Software can switch in a per-pin deglitch filter, which lets a new level through only after two equal consecutive samples. The resulting level, filtered or raw, goes back to the peripherals. It is also compared with its previous value, and any difference sets a sticky per-pin change flag. The interrupt line is high while any flagged pin also has its interrupt enable set.

The control registers sit behind an APB slave with no wait states. Each frequently written register has three aliases: one sets bits, one clears bits, and one reads the register. Writing a 0 bit through the set or clear alias leaves that bit as it was. Reading the change-flag register clears it.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After reset, pad_oe is 0, irq is 0, the ownership register reads all ones, and the output-enable, output-data, filter-enable, interrupt-enable and change-flag registers read 0.
- R2: Register groups sit at offsets 0x00 (ownership), 0x10 (software output enable), 0x20 (software output data), 0x30 (filter enable) and 0x40 (interrupt enable). Within a group, +0x0 is the set alias, +0x4 is the clear alias and +0x8 is the read alias. Writing the set alias ORs pwdata into the register, and 0 bits have no effect.
- R3: Writing the clear alias clears the bits that are 1 in pwdata, and 0 bits have no effect.
- R4: For each pin, pad_out and pad_oe equal the software output data and software output enable when the ownership bit is 1. They equal per_out and per_oe when the ownership bit is 0.
- R5: With the filter off, per_in follows pad_in after exactly two rising clock edges. The pin-level register at 0x54 reads the synchronized pad level whatever the ownership.
- R6: With a pin's filter bit set, a pad pulse lasting one clock is not passed to per_in and flags no change. A level held steady reaches per_in two edges later than it would unfiltered, which is four edges after the pad changes.
- R7: A rising or falling change of a pin's per_in level sets that pin's bit in the change-flag register at 0x50, one edge after per_in changes. The bit stays set until the register is read.
- R8: A read of 0x50 returns the flags as they were before the access and clears them. A change detected on the same edge as the read is kept.
- R9: irq is 1 exactly when some pin has both its change flag and its interrupt-enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| pad_in | input | 32 | Levels seen at the pads |
| pad_out | output | 32 | Data driven to the pads |
| pad_oe | output | 32 | Pad output enables, 1 drives |
| per_out | input | 32 | Peripheral output data |
| per_oe | input | 32 | Peripheral output enables |
| per_in | output | 32 | Conditioned pad levels to the peripherals |
| irq | output | 1 | Interrupt request |

## Verification
A wrong ownership or output-register bit shows at pad_out or pad_oe as soon as the APB write completes, because the pad mux has no pipeline. A fault in the synchronizer or filter shifts the edge on which per_in moves. The bench therefore samples per_in on each edge around the expected one, so a stage too many or too few is caught within one cycle. A change flag that is lost, not sticky, or wrongly cleared shows at irq and in the next read of the flag register. This includes a change that lands on the same edge as the clearing read.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;
  localparam int APB_AW   = 8;
  localparam int NUM_RW   = 5;
  // register group in paddr[7:4]
  localparam logic [3:0] GRP_OWN  = 4'h0;
  localparam logic [3:0] GRP_OE   = 4'h1;
  localparam logic [3:0] GRP_DOUT = 4'h2;
  localparam logic [3:0] GRP_FILT = 4'h3;
  localparam logic [3:0] GRP_IEN  = 4'h4;
  localparam logic [3:0] GRP_STAT = 4'h5;
  // alias in paddr[3:2]
  localparam logic [1:0] AL_SET = 2'd0;
  localparam logic [1:0] AL_CLR = 2'd1;
  localparam logic [1:0] AL_RD  = 2'd2;
  // status group aliases
  localparam logic [1:0] AL_FLAGS = 2'd0;
  localparam logic [1:0] AL_LEVEL = 2'd1;
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int          W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (set_we)      q_nxt = q | wdata;
    else if (clr_we) q_nxt = q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= RST_VAL;
    else if (set_we || clr_we) q <= q_nxt;
  end

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((q & $past(wdata)) == $past(wdata)) &&
               ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((q & $past(wdata)) == '0) &&
                            ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
endmodule

// File: rtl/gpio_in_cond.sv
module gpio_in_cond #(
  parameter int N           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pad_in,
  input  logic [N-1:0] filt_en,
  output logic [N-1:0] sync_lvl,
  output logic [N-1:0] cond_lvl,
  output logic [N-1:0] chg
);
  logic [N-1:0] sync_q [SYNC_STAGES];
  logic [N-1:0] hist_q, filt_q, prev_q;
  logic [N-1:0] filt_d, agree;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  sync_q[s] <= '0;
        else if (s == 0) sync_q[s] <= pad_in;
        else         sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_lvl = sync_q[SYNC_STAGES-1];

  always_comb begin
    agree    = ~(sync_lvl ^ hist_q);
    filt_d   = (sync_lvl & agree) | (filt_q & ~agree);
    cond_lvl = (filt_en & filt_q) | (~filt_en & sync_lvl);
    chg      = cond_lvl ^ prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      filt_q <= '0;
      prev_q <= '0;
    end else begin
      hist_q <= sync_lvl;
      filt_q <= filt_d;
      prev_q <= cond_lvl;
    end
  end

  // a filtered level may only rise after two equal high samples
  assert_filt_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt_q & ~$past(filt_q)) & ~($past(sync_lvl) & $past(hist_q))) == '0);

  assert_filt_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((~filt_q & $past(filt_q)) & ($past(sync_lvl) | $past(hist_q))) == '0);
endmodule

// File: rtl/gpio_apb_regs.sv
module gpio_apb_regs
  import gpio_pin_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [APB_AW-1:0] paddr,
  input  logic [N-1:0]      pwdata,
  output logic [N-1:0]      prdata,
  input  logic [N-1:0]      chg,
  input  logic [N-1:0]      sync_lvl,
  output logic [N-1:0]      sw_own,
  output logic [N-1:0]      sw_oe,
  output logic [N-1:0]      sw_dout,
  output logic [N-1:0]      filt_en,
  output logic              irq
);
  logic [N-1:0] reg_q [NUM_RW];
  logic [N-1:0] flags_q, flags_d;
  logic         acc, wr, rd, rd_flags;
  logic [3:0]   grp;
  logic [1:0]   als;
  logic [N-1:0] ien;

  assign acc      = psel && penable && (paddr[1:0] == 2'b00);
  assign wr       = acc && pwrite;
  assign rd       = acc && !pwrite;
  assign grp      = paddr[7:4];
  assign als      = paddr[3:2];
  assign rd_flags = rd && (grp == GRP_STAT) && (als == AL_FLAGS);

  genvar g;
  generate
    for (g = 0; g < NUM_RW; g++) begin : g_rw
      logic hit;
      assign hit = wr && (grp == 4'(g));
      gpio_setclr_reg #(
        .W      (N),
        .RST_VAL((g == int'(GRP_OWN)) ? {N{1'b1}} : {N{1'b0}})
      ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .set_we(hit && (als == AL_SET)),
        .clr_we(hit && (als == AL_CLR)),
        .wdata (pwdata),
        .q     (reg_q[g])
      );
    end
  endgenerate

  assign sw_own  = reg_q[GRP_OWN];
  assign sw_oe   = reg_q[GRP_OE];
  assign sw_dout = reg_q[GRP_DOUT];
  assign filt_en = reg_q[GRP_FILT];
  assign ien     = reg_q[GRP_IEN];

  always_comb begin
    flags_d = (rd_flags ? '0 : flags_q) | chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  always_comb begin
    prdata = '0;
    if (rd) begin
      if (grp < 4'(NUM_RW)) begin
        if (als == AL_RD) prdata = reg_q[grp[2:0]];
      end else if (grp == GRP_STAT) begin
        if (als == AL_FLAGS)      prdata = flags_q;
        else if (als == AL_LEVEL) prdata = sync_lvl;
      end
    end
  end

  assign irq = |(flags_q & ien);

  assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_flags |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  assert_flags_rdclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_flags |=> (flags_q == $past(chg)));

  assert_flags_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & ~$past(flags_q)) & ~$past(chg)) == '0);
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_pin_pkg::*;
#(
  parameter int N           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [APB_AW-1:0] paddr,
  input  logic [N-1:0]      pwdata,
  output logic [N-1:0]      prdata,
  input  logic [N-1:0]      pad_in,
  output logic [N-1:0]      pad_out,
  output logic [N-1:0]      pad_oe,
  input  logic [N-1:0]      per_out,
  input  logic [N-1:0]      per_oe,
  output logic [N-1:0]      per_in,
  output logic              irq
);
  logic [N-1:0] sw_own, sw_oe, sw_dout, filt_en, sync_lvl, chg;

  gpio_apb_regs #(.N(N)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .chg     (chg),
    .sync_lvl(sync_lvl),
    .sw_own  (sw_own),
    .sw_oe   (sw_oe),
    .sw_dout (sw_dout),
    .filt_en (filt_en),
    .irq     (irq)
  );

  gpio_in_cond #(.N(N), .SYNC_STAGES(SYNC_STAGES)) u_in (
    .clk     (clk),
    .rst_n   (rst_n),
    .pad_in  (pad_in),
    .filt_en (filt_en),
    .sync_lvl(sync_lvl),
    .cond_lvl(per_in),
    .chg     (chg)
  );

  always_comb begin
    pad_out = (sw_own & sw_dout) | (~sw_own & per_out);
    pad_oe  = (sw_own & sw_oe)   | (~sw_own & per_oe);
  end

  // a pin left to software never shows the peripheral's enable
  assert_own_isolate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(sw_own) && $stable(sw_oe) |-> ((pad_oe & sw_own) == ($past(pad_oe) & sw_own)));
endmodule

// File: tb/gpio_pin_ctrl_tb_top.sv
module gpio_pin_ctrl_tb_top;
  logic        clk, rst_n;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata, pad_in, pad_out, pad_oe, per_out, per_oe, per_in;
  logic        irq;
  int          n_run, n_fail;
  logic        done;
  logic [31:0] rv;

  gpio_pin_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .per_out(per_out), .per_oe(per_oe),
    .per_in(per_in), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [31:0] own, oe, dout, pout, poe;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hA5A5A5A5, 32'h5A5A5A5A, 32'h00000000},
    '{32'h00000000, 32'hFFFFFFFF, 32'hA5A5A5A5, 32'h5A5A5A5A, 32'h0F0F0F0F},
    '{32'hFFFF0000, 32'h0000FFFF, 32'h12345678, 32'h87654321, 32'hFFFFFFFF},
    '{32'h0F0F0F0F, 32'h00FF00FF, 32'hFFFFFFFF, 32'h00000000, 32'hF0F0F0F0},
    '{32'h80000001, 32'h80000000, 32'h00000001, 32'hFFFFFFFF, 32'h7FFFFFFE},
    '{32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    done = 1'b0;
    #(200000 * 4);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; pad_in = '0; per_out = '0; per_oe = 32'hFFFFFFFF;
    repeat (3) @(negedge clk);
    chk("R1 pad_oe in reset", pad_oe, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    apb_rd(8'h08, rv); chk("R1 own", rv, 32'hFFFFFFFF);
    apb_rd(8'h18, rv); chk("R1 oe", rv, 32'h0);
    apb_rd(8'h28, rv); chk("R1 dout", rv, 32'h0);
    apb_rd(8'h38, rv); chk("R1 filt", rv, 32'h0);
    apb_rd(8'h48, rv); chk("R1 ien", rv, 32'h0);
    apb_rd(8'h50, rv); chk("R1 flags", rv, 32'h0);

    // set / clear aliases
    apb_wr(8'h20, 32'h000000F0);
    apb_wr(8'h20, 32'h0000000F);
    apb_rd(8'h28, rv); chk("R2 set keeps zeros", rv, 32'h000000FF);
    apb_wr(8'h24, 32'h0000000F);
    apb_rd(8'h28, rv); chk("R3 clear keeps zeros", rv, 32'h000000F0);
    apb_wr(8'h24, 32'h00000000);
    apb_rd(8'h28, rv); chk("R3 clear of zero", rv, 32'h000000F0);

    // pad mux table
    for (int i = 0; i < 6; i++) begin
      apb_wr(8'h00, VEC[i].own);  apb_wr(8'h04, ~VEC[i].own);
      apb_wr(8'h10, VEC[i].oe);   apb_wr(8'h14, ~VEC[i].oe);
      apb_wr(8'h20, VEC[i].dout); apb_wr(8'h24, ~VEC[i].dout);
      per_out = VEC[i].pout; per_oe = VEC[i].poe;
      #1;
      chk("R4 pad_out", pad_out, (VEC[i].own & VEC[i].dout) | (~VEC[i].own & VEC[i].pout));
      chk("R4 pad_oe", pad_oe, (VEC[i].own & VEC[i].oe) | (~VEC[i].own & VEC[i].poe));
      apb_rd(8'h08, rv); chk("R2 own readback", rv, VEC[i].own);
    end

    // hand every pin to the peripheral side; level register ignores ownership
    apb_wr(8'h04, 32'hFFFFFFFF);
    apb_wr(8'h40, 32'h00000008);
    apb_rd(8'h50, rv); chk("R8 flags idle", rv, 32'h0);

    // unfiltered rise on pin 3
    @(negedge clk); pad_in[3] = 1'b1;
    @(posedge clk); #1 chk("R5 after one edge", per_in, 32'h0);
    @(posedge clk); #1 chk("R5 after two edges", per_in, 32'h8);
    chk("R7 irq not yet", {31'h0, irq}, 32'h0);
    @(posedge clk); #1 chk("R7 irq on rise", {31'h0, irq}, 32'h1);
    apb_rd(8'h54, rv); chk("R5 level reg", rv, 32'h8);
    apb_rd(8'h50, rv); chk("R8 flags read", rv, 32'h8);
    chk("R8 irq after read", {31'h0, irq}, 32'h0);
    @(negedge clk); pad_in[3] = 1'b0;
    repeat (4) @(posedge clk);
    #1 chk("R7 irq on fall", {31'h0, irq}, 32'h1);
    apb_rd(8'h50, rv); chk("R7 fall flag", rv, 32'h8);

    // filtered pin 5: one-cycle pulse rejected
    apb_wr(8'h30, 32'h00000020);
    @(negedge clk); pad_in[5] = 1'b1;
    @(negedge clk); pad_in[5] = 1'b0;
    repeat (6) @(posedge clk);
    #1 chk("R6 pulse blocked", per_in, 32'h0);
    apb_rd(8'h50, rv); chk("R6 no flag", rv, 32'h0);
    @(negedge clk); pad_in[5] = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R6 not before four edges", per_in, 32'h0);
    @(posedge clk); #1 chk("R6 passes at four edges", per_in, 32'h20);
    apb_rd(8'h50, rv); chk("R6 steady flag", rv, 32'h20);

    // change lands on the same edge as a clearing read (pin 7, unfiltered)
    @(negedge clk); pad_in[7] = 1'b1;
    psel = 1'b0;
    @(negedge clk); psel = 1'b1; pwrite = 1'b0; paddr = 8'h50; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    #1 chk("R8 old flags returned", prdata, 32'h0);
    @(negedge clk); psel = 1'b0; penable = 1'b0;
    chk("R9 masked flag no irq", {31'h0, irq}, 32'h0);
    apb_wr(8'h40, 32'h00000080);
    #1 chk("R9 unmask raises irq", {31'h0, irq}, 32'h1);
    apb_rd(8'h50, rv); chk("R8 same-edge change kept", rv, 32'h80);
    chk("R9 irq drops", {31'h0, irq}, 32'h0);

    done = 1'b1;
    summary();
  end
endmodule